// File: doc/BRIEF.md
# Clocked Serial Receiver with Clock-Hold Flow Control

This block is the receive side of a synchronous serial link on which it is the clock master. It generates the serial clock, samples one data line on each rising clock edge, and assembles 8-bit frames, least significant bit first. Finished frames go into receive storage, which can be one of three depths: the shift register alone, the shift register plus a holding buffer, or those two plus a small first-in first-out queue.

Received data is never overwritten. When every storage stage holds an unread frame, the block does not start another frame. It leaves its serial clock parked at the high level until software frees a stage by reading. Software always reads through one data port, which presents the oldest unread frame. A configuration bit can also make the block drop its own receive enable when storage fills, so reception stays halted until software enables it again.

Top module: `chrx_top`

## Requirements
- R1: After reset and whenever the receiver is waiting, `sclk` is high. A frame starts with a falling edge. Each bit then takes HALF_DIV system clocks low followed by HALF_DIV system clocks high. No frame starts while `rx_en` is 0.
- R2: `rxd` is sampled on each rising `sclk` edge. The first bit sampled becomes bit 0 of the frame. `rd_data` always shows the oldest unread frame, and frames are read in the order they arrived.
- R3: With `mode` = 2'b00 (single stage), at most one frame is held. The clock stops after each frame, and a read lets the next frame start.
- R4: With `mode` = 2'b01 (two stages), up to two frames are held before the clock stops. One read lets reception resume.
- R5: With `mode` = 2'b10 (queued), up to DEPTH+2 frames are held. `fifo_full` is 1 while the block is stopped at that capacity. `fifo_empty` is 1 once all frames have been read.
- R6: `data_ready` is 1 exactly while at least one unread frame is held. A read that removes the only held frame clears it.
- R7: When `halt_on_full` is 1 and storage reaches capacity, `rx_en` drops to 0. Later reads do not restart the clock until a pulse on `rx_en_set`.
- R8: `overrun` is always 0, and the number of held frames never exceeds the capacity of the selected mode.
- R9: A read strobe while no frame is held has no effect on the flags or on the order of later data.
- R10: During reset the outputs settle to `sclk`=1, `rx_en`=0, `data_ready`=0, `fifo_empty`=1, `fifo_full`=0 and `overrun`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | Storage depth select: 00 single, 01 two-stage, 10 queued |
| rx_en_set | input | 1 | One-cycle pulse that sets the receive enable |
| halt_on_full | input | 1 | Clear the receive enable when storage fills |
| rd_strobe | input | 1 | Read strobe; removes the frame shown on rd_data |
| rxd | input | 1 | Serial data in |
| sclk | output | 1 | Serial clock out, idles high |
| rd_data | output | DATA_W | Oldest unread frame |
| data_ready | output | 1 | At least one unread frame is held |
| fifo_empty | output | 1 | Queue holds no frame |
| fifo_full | output | 1 | Queue holds DEPTH frames |
| rx_en | output | 1 | Receive enable state |
| overrun | output | 1 | Overrun indication, held at 0 |

## Verification
The risky overlap is a software read landing in the same clock as a frame completing, or as the holding buffer moving a frame into the queue. In that cycle the read must take the oldest frame while the stages behind it shift forward. The bench provokes this by reading at staggered delays, spread over a whole frame time, while the queued receiver keeps running. It judges the result by comparing `data_ready` on every clock against a count of frames sent minus frames read, and by checking each read value against the next frame sent.

// File: rtl/chrx_pkg.sv
package chrx_pkg;

    localparam int CHRX_DATA_W = 8;

    typedef enum logic [1:0] {
        CHRX_SINGLE = 2'b00,
        CHRX_DOUBLE = 2'b01,
        CHRX_QUEUE  = 2'b10,
        CHRX_QUEUE2 = 2'b11
    } chrx_mode_e;

    // number of frames the storage can hold in a given mode
    function automatic int chrx_capacity(chrx_mode_e m, int depth);
        case (m)
            CHRX_SINGLE: return 1;
            CHRX_DOUBLE: return 2;
            default:     return depth + 2;
        endcase
    endfunction

    function automatic logic chrx_uses_buf(chrx_mode_e m);
        return m != CHRX_SINGLE;
    endfunction

    function automatic logic chrx_uses_queue(chrx_mode_e m);
        return m[1];
    endfunction

endpackage

// File: rtl/chrx_fifo.sv
module chrx_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         push,
    input  logic                         pop,
    input  logic [W-1:0]                 din,
    output logic [W-1:0]                 head,
    output logic [$clog2(DEPTH+1)-1:0]   count,
    output logic                         empty,
    output logic                         full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wr_q, rd_q;
    logic [CW-1:0] cnt_q;

    function automatic logic [PW-1:0] nxt(logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (push) begin
                mem[wr_q] <= din;
                wr_q      <= nxt(wr_q);
            end
            if (pop) rd_q <= nxt(rd_q);
            cnt_q <= cnt_q + CW'(push) - CW'(pop);
        end
    end

    assign head  = mem[rd_q];
    assign count = cnt_q;
    assign empty = (cnt_q == '0);
    assign full  = (cnt_q == CW'(DEPTH));

    assert_queue_no_push_full_R8: assert property (@(posedge clk) disable iff (rst)
        (push && full) |-> pop);
    assert_queue_no_pop_empty_R9: assert property (@(posedge clk) disable iff (rst)
        pop |-> !empty);

endmodule

// File: rtl/chrx_shifter.sv
module chrx_shifter #(
    parameter int W        = 8,
    parameter int HALF_DIV = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         rx_en,
    input  logic         hold,
    input  logic         rxd,
    output logic         sclk,
    output logic         done,
    output logic [W-1:0] dout
);
    localparam int DW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam int BW = $clog2(W);

    logic          active_q, sclk_q;
    logic [DW-1:0] div_q;
    logic [BW-1:0] bit_q;
    logic [W-2:0]  sh_q;
    logic          tick, rise;

    assign tick = active_q && (div_q == DW'(HALF_DIV - 1));
    assign rise = tick && !sclk_q;
    assign done = rise && (bit_q == BW'(W - 1));
    assign dout = {rxd, sh_q};
    assign sclk = sclk_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            sclk_q   <= 1'b1;
            div_q    <= '0;
            bit_q    <= '0;
            sh_q     <= '0;
        end else if (!active_q) begin
            if (rx_en && !hold) begin
                active_q <= 1'b1;
                sclk_q   <= 1'b0;
                div_q    <= '0;
                bit_q    <= '0;
            end
        end else if (tick) begin
            div_q  <= '0;
            sclk_q <= !sclk_q;
            if (rise) begin
                sh_q  <= {rxd, sh_q[W-2:1]};
                bit_q <= bit_q + 1'b1;
                if (done) active_q <= 1'b0;
            end
        end else begin
            div_q <= div_q + 1'b1;
        end
    end

    assert_held_no_start_R3: assert property (@(posedge clk) disable iff (rst)
        (!active_q && hold) |=> !active_q);
    assert_frame_ends_high_R1: assert property (@(posedge clk) disable iff (rst)
        done |=> (sclk_q && !active_q));
    assert_disabled_no_start_R1: assert property (@(posedge clk) disable iff (rst)
        (!active_q && !rx_en) |=> !active_q);

endmodule

// File: rtl/chrx_store.sv
module chrx_store
    import chrx_pkg::*;
#(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  chrx_mode_e   mode,
    input  logic         done,
    input  logic [W-1:0] din,
    input  logic         rd,
    output logic [W-1:0] rd_data,
    output logic         avail,
    output logic         sr_busy,
    output logic         at_capacity,
    output logic         q_empty,
    output logic         q_full
);
    localparam int FCW = $clog2(DEPTH + 1);
    localparam int TCW = $clog2(DEPTH + 3);

    typedef struct packed {
        logic         full;
        logic [W-1:0] data;
    } stage_t;

    stage_t         sr_q, bf_q;
    logic [W-1:0]   q_head;
    logic [FCW-1:0] q_cnt;
    logic           use_buf, use_q, q_has;
    logic           pop_q, pop_bf, pop_sr, push_q, bf_leave, load_bf;
    logic [TCW-1:0] total;

    always_comb begin
        use_buf  = chrx_uses_buf(mode);
        use_q    = chrx_uses_queue(mode);
        q_has    = use_q && !q_empty;
        pop_q    = rd && q_has;
        pop_bf   = rd && !q_has && bf_q.full;
        pop_sr   = rd && !q_has && !bf_q.full && sr_q.full;
        push_q   = use_q && bf_q.full && !pop_bf && (!q_full || pop_q);
        bf_leave = pop_bf || push_q;
        load_bf  = use_buf && sr_q.full && !pop_sr && (!bf_q.full || bf_leave);
    end

    chrx_fifo #(.W(W), .DEPTH(DEPTH)) u_queue (
        .clk   (clk),
        .rst   (rst),
        .push  (push_q),
        .pop   (pop_q),
        .din   (bf_q.data),
        .head  (q_head),
        .count (q_cnt),
        .empty (q_empty),
        .full  (q_full)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            sr_q <= '0;
            bf_q <= '0;
        end else begin
            if (done) begin
                sr_q.data <= din;
                sr_q.full <= 1'b1;
            end else if (pop_sr || load_bf) begin
                sr_q.full <= 1'b0;
            end
            if (load_bf) begin
                bf_q.data <= sr_q.data;
                bf_q.full <= 1'b1;
            end else if (bf_leave) begin
                bf_q.full <= 1'b0;
            end
        end
    end

    always_comb begin
        if (q_has)          rd_data = q_head;
        else if (bf_q.full) rd_data = bf_q.data;
        else                rd_data = sr_q.data;
    end

    assign avail       = q_has || bf_q.full || sr_q.full;
    assign sr_busy     = sr_q.full;
    assign total       = TCW'(q_cnt) + TCW'(bf_q.full) + TCW'(sr_q.full);
    assign at_capacity = (total == TCW'(chrx_capacity(mode, DEPTH)));

    assert_no_overwrite_R8: assert property (@(posedge clk) disable iff (rst)
        done |-> !sr_q.full);
    assert_last_read_clears_R6: assert property (@(posedge clk) disable iff (rst)
        (rd && total == TCW'(1) && !done) |=> !avail);
    assert_empty_read_ignored_R9: assert property (@(posedge clk) disable iff (rst)
        (rd && !avail && !done) |=> !avail);

endmodule

// File: rtl/chrx_top.sv
module chrx_top
    import chrx_pkg::*;
#(
    parameter int DATA_W   = CHRX_DATA_W,
    parameter int HALF_DIV = 4,
    parameter int DEPTH    = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        mode,
    input  logic              rx_en_set,
    input  logic              halt_on_full,
    input  logic              rd_strobe,
    input  logic              rxd,
    output logic              sclk,
    output logic [DATA_W-1:0] rd_data,
    output logic              data_ready,
    output logic              fifo_empty,
    output logic              fifo_full,
    output logic              rx_en,
    output logic              overrun
);
    chrx_mode_e        mode_e;
    logic              en_q, done, hold, cap_hit;
    logic [DATA_W-1:0] frame;

    assign mode_e = chrx_mode_e'(mode);

    always_ff @(posedge clk) begin
        if (rst)                         en_q <= 1'b0;
        else if (rx_en_set)              en_q <= 1'b1;
        else if (halt_on_full && cap_hit) en_q <= 1'b0;
    end

    chrx_shifter #(.W(DATA_W), .HALF_DIV(HALF_DIV)) u_shift (
        .clk   (clk),
        .rst   (rst),
        .rx_en (en_q),
        .hold  (hold),
        .rxd   (rxd),
        .sclk  (sclk),
        .done  (done),
        .dout  (frame)
    );

    chrx_store #(.W(DATA_W), .DEPTH(DEPTH)) u_store (
        .clk         (clk),
        .rst         (rst),
        .mode        (mode_e),
        .done        (done),
        .din         (frame),
        .rd          (rd_strobe),
        .rd_data     (rd_data),
        .avail       (data_ready),
        .sr_busy     (hold),
        .at_capacity (cap_hit),
        .q_empty     (fifo_empty),
        .q_full      (fifo_full)
    );

    assign rx_en   = en_q;
    assign overrun = 1'b0;

    assert_halt_drops_enable_R7: assert property (@(posedge clk) disable iff (rst)
        (halt_on_full && cap_hit && !rx_en_set) |=> !rx_en);
    assert_full_clock_parked_R1: assert property (@(posedge clk) disable iff (rst)
        (cap_hit && hold) |=> sclk);

endmodule

// File: tb/sim_chrx_top.sv
module sim_chrx_top;
    localparam int HALF_DIV = 4;
    localparam int DEPTH    = 4;
    localparam int W        = 8;

    logic         clk = 1'b0, rst = 1'b1;
    logic [1:0]   mode = 2'b00;
    logic         rx_en_set = 1'b0, halt = 1'b0, rd = 1'b0, rxd = 1'b1;
    logic         sclk, data_ready, fifo_empty, fifo_full, rx_en, overrun;
    logic [W-1:0] rd_data;

    int checks = 0, failures = 0;
    int completed = 0, rd_idx = 0, bitpos = 0;
    bit fell = 1'b0, mon_on = 1'b0;

    always #4 clk = ~clk;

    chrx_top #(.DATA_W(W), .HALF_DIV(HALF_DIV), .DEPTH(DEPTH)) u0 (
        .clk(clk), .rst(rst), .mode(mode), .rx_en_set(rx_en_set),
        .halt_on_full(halt), .rd_strobe(rd), .rxd(rxd), .sclk(sclk),
        .rd_data(rd_data), .data_ready(data_ready), .fifo_empty(fifo_empty),
        .fifo_full(fifo_full), .rx_en(rx_en), .overrun(overrun)
    );

    function automatic logic [W-1:0] pat(int k);
        return W'((k * 73 + 29) ^ (k >> 1));
    endfunction

    function automatic int cap(logic [1:0] m);
        return (m == 2'b00) ? 1 : (m == 2'b01) ? 2 : DEPTH + 2;
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // remote device: drives the next bit after each falling clock edge
    initial begin
        forever begin
            @(negedge sclk);
            fell = 1'b1;
            #1;
            begin
                logic [W-1:0] cur;
                cur = pat(completed);
                rxd = cur[bitpos];
            end
        end
    end

    // counts sampled bits and finished frames
    initial begin
        forever begin
            @(posedge sclk);
            if (fell) begin
                fell = 1'b0;
                bitpos++;
                if (bitpos == W) begin
                    bitpos = 0;
                    completed++;
                end
            end
        end
    end

    // per-clock comparison against the behavioural frame count
    initial begin
        forever begin
            @(negedge clk);
            if (mon_on) begin
                int held;
                held = completed - rd_idx;
                chk(data_ready == (held > 0), "R6 data_ready vs held frames", data_ready, held > 0);
                chk(overrun == 1'b0, "R8 overrun held low", overrun, 0);
                chk(held <= cap(mode), "R8 held frames within capacity", held, cap(mode));
                if (held == cap(mode))
                    chk(sclk == 1'b1, "R1 clock parked high when full", sclk, 1);
            end
        end
    end

    task automatic wait_cycles(int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic pulse_en();
        @(negedge clk); rx_en_set = 1'b1;
        @(negedge clk); rx_en_set = 1'b0;
    endtask

    task automatic do_read(string req);
        while (completed <= rd_idx) @(negedge clk);
        @(negedge clk);
        #1;
        chk(rd_data == pat(rd_idx), req, rd_data, pat(rd_idx));
        rd = 1'b1;
        @(posedge clk);
        #1;
        rd = 1'b0;
        rd_idx++;
    endtask

    // watchdog
    initial begin
        wait_cycles(150000);
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", checks, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        wait_cycles(2);
        @(negedge clk);
        chk(sclk == 1'b1, "R10 reset sclk", sclk, 1);
        chk(rx_en == 1'b0, "R10 reset rx_en", rx_en, 0);
        chk(data_ready == 1'b0, "R10 reset data_ready", data_ready, 0);
        chk(fifo_empty == 1'b1, "R10 reset fifo_empty", fifo_empty, 1);
        chk(fifo_full == 1'b0, "R10 reset fifo_full", fifo_full, 0);
        chk(overrun == 1'b0, "R10 reset overrun", overrun, 0);
        rst = 1'b0;
        mon_on = 1'b1;

        wait_cycles(100);
        chk(completed == 0, "R1 no frame while disabled", completed, 0);

        // single stage
        pulse_en();
        wait_cycles(200);
        chk(completed == 1, "R3 single holds one frame", completed, 1);
        chk(sclk == 1'b1, "R3 clock stopped high", sclk, 1);
        do_read("R2 first frame value");
        wait_cycles(200);
        chk(completed == 2, "R3 read restarts clock", completed, 2);
        do_read("R2 second frame value");
        @(negedge clk); halt = 1'b1;
        wait_cycles(200);
        chk(rx_en == 1'b0, "R7 enable dropped on full", rx_en, 0);
        do_read("R7 frame before halt");
        wait_cycles(200);
        chk(completed == 3, "R7 read does not restart", completed, 3);

        // read with nothing held
        @(negedge clk); rd = 1'b1;
        @(posedge clk); #1 rd = 1'b0;
        wait_cycles(2);
        chk(data_ready == 1'b0, "R9 empty read ignored", data_ready, 0);
        chk(fifo_empty == 1'b1, "R9 queue still empty", fifo_empty, 1);

        // two stages
        @(negedge clk); halt = 1'b0; mode = 2'b01;
        pulse_en();
        wait_cycles(400);
        chk(completed - rd_idx == 2, "R4 two frames held", completed - rd_idx, 2);
        chk(sclk == 1'b1, "R4 clock stopped high", sclk, 1);
        do_read("R9 order after empty read");
        @(negedge clk);
        chk(data_ready == 1'b1, "R6 flag stays with frame behind", data_ready, 1);
        wait_cycles(300);
        chk(completed - rd_idx == 2, "R4 one read resumes", completed - rd_idx, 2);
        @(negedge clk); halt = 1'b1;
        wait_cycles(5);
        chk(rx_en == 1'b0, "R7 enable dropped when already full", rx_en, 0);
        do_read("R4 drain first");
        do_read("R4 drain second");
        wait_cycles(3);
        chk(data_ready == 1'b0, "R6 cleared after last read", data_ready, 0);

        // queued
        @(negedge clk); halt = 1'b0; mode = 2'b10;
        pulse_en();
        wait_cycles(800);
        chk(completed - rd_idx == DEPTH + 2, "R5 full capacity held", completed - rd_idx, DEPTH + 2);
        chk(fifo_full == 1'b1, "R5 queue full flag", fifo_full, 1);
        chk(sclk == 1'b1, "R5 clock stopped high", sclk, 1);
        do_read("R5 first queued frame");
        wait_cycles(200);
        chk(completed - rd_idx == DEPTH + 2, "R5 resume after one read", completed - rd_idx, DEPTH + 2);

        // reads at staggered offsets while frames keep arriving
        for (int i = 0; i < 16; i++) begin
            wait_cycles((i * 13) % 70);
            do_read("R2 order under concurrent reads");
        end
        @(negedge clk); halt = 1'b1;
        wait_cycles(800);
        chk(rx_en == 1'b0, "R7 queued halt", rx_en, 0);
        while (completed > rd_idx) do_read("R5 drain in order");
        wait_cycles(3);
        chk(fifo_empty == 1'b1, "R5 queue empty flag", fifo_empty, 1);
        chk(fifo_full == 1'b0, "R5 queue not full", fifo_full, 0);
        chk(data_ready == 1'b0, "R6 nothing held", data_ready, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule